// File: doc/BRIEF.md
# Processor Status Register with Interrupt Entry Sequencer

This block holds the 8-bit status word of a small accumulator CPU. It also decides, at each instruction boundary, whether the core fetches the next instruction or enters an interrupt. The low three bits are general flags, and each drives an output pin. Bit 3 is the interrupt enable. Bits 4 and 5 show two synchronized sense inputs, and the first of these is the interrupt request. Bit 6 holds overflow and bit 7 holds carry.

The core changes the word in three ways. It can load the whole word from the accumulator, issue explicit enable and disable commands, or update the arithmetic flags from the ALU. The word is always readable on a port, so it can be copied back into the accumulator.

Before each fetch the core raises a fetch request. If the enable bit is set and the synchronized request bit is high, the block withholds the fetch grant and clears the enable bit. In the next cycle it pulses an exchange strobe, which makes the pointer file swap the program counter with pointer register 3. Nothing is pushed onto a stack. Control returns only through a later exchange of the same kind, issued by software.

Top module: `psr_irq_ctrl`

## Requirements
- R1: While rst_ni is low and after it is released, every status bit, the flag pins and irq_xchg_o read 0, so interrupts start disabled.
- R2: Bits 0 to 2 of sr_o drive usr_flag_o[2:0] and change only on an accumulator write, which loads acc_wdata_i[2:0].
- R3: The enable bit is sr_o[3]. ien_clr_i clears it and ien_set_i sets it at the next edge, and when both are high the clear wins.
- R4: An accumulator write (acc_wr_i) loads bits 0-3, 6 and 7 from acc_wdata_i and takes priority over the enable and disable commands and over the ALU update. The write data for bits 4 and 5 is ignored.
- R5: sr_o[4] follows irq_sense_i and sr_o[5] follows aux_sense_i through a two-flop synchronizer, so a change is visible after the second rising edge.
- R6: When alu_flag_we_i is high and no accumulator write occurs, sr_o[6] loads alu_ov_i and sr_o[7] loads alu_cy_i.
- R7: An interrupt is taken in a cycle only when fetch_req_i, sr_o[3] and sr_o[4] are all high and no exchange is pending. Otherwise fetch_go_o equals fetch_req_i in the same cycle.
- R8: When an interrupt is taken, fetch_go_o stays low in that cycle. The enable bit clears at the next edge, and irq_xchg_o is high for exactly the following cycle, during which fetch_go_o also stays low.
- R9: In the cycle an interrupt is taken, clearing the enable bit wins over ien_set_i and over an accumulator write of bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_sense_i | input | 1 | Asynchronous interrupt request sense line |
| aux_sense_i | input | 1 | Asynchronous auxiliary sense line |
| acc_wr_i | input | 1 | Load the status word from the accumulator |
| acc_wdata_i | input | 8 | Accumulator value to load |
| ien_clr_i | input | 1 | Disable-interrupts command |
| ien_set_i | input | 1 | Enable-interrupts command |
| alu_flag_we_i | input | 1 | ALU flag update strobe |
| alu_ov_i | input | 1 | ALU overflow result |
| alu_cy_i | input | 1 | ALU carry result |
| fetch_req_i | input | 1 | Core is ready to fetch the next instruction |
| fetch_go_o | output | 1 | Fetch may proceed |
| irq_xchg_o | output | 1 | One-cycle strobe: swap program counter with pointer register 3 |
| sr_o | output | 8 | Full status word, read by the accumulator |
| usr_flag_o | output | 3 | General flag pins |

## Verification
Every status bit is visible on sr_o, so a wrong bit is seen one cycle after the edge that corrupted it. A sequencer fault shows up at the next fetch request as a wrong fetch_go_o, or as an exchange strobe that is missing, doubled or mistimed. A fault in the synchronizer depth appears as sense bits that are off by one cycle. The bench drives random and directed patterns, including same-cycle conflicts between writers, against a cycle model and compares every output in every cycle.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned SR_W      = 8;
  localparam int unsigned USR_W     = 3;
  localparam int unsigned SNS_W     = 2;
  localparam int unsigned SYNC_LEN  = 2;
  localparam int unsigned BIT_IEN   = 3;
  localparam int unsigned BIT_SNS_A = 4;
  localparam int unsigned BIT_SNS_B = 5;
  localparam int unsigned BIT_OV    = 6;
  localparam int unsigned BIT_CY    = 7;

  typedef struct packed {
    logic             cy;
    logic             ov;
    logic             sns_b;
    logic             sns_a;
    logic             ien;
    logic [USR_W-1:0] usr;
  } psr_t;
endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/psr_irq_seq.sv
module psr_irq_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fetch_req_i,
  input  logic ien_i,
  input  logic req_i,
  output logic take_o,
  output logic xchg_o,
  output logic fetch_go_o
);
  logic xchg_q;

  // decision made at the fetch boundary; exchange strobe follows one cycle later
  assign take_o     = fetch_req_i & ien_i & req_i & ~xchg_q;
  assign fetch_go_o = fetch_req_i & ~take_o & ~xchg_q;
  assign xchg_o     = xchg_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) xchg_q <= 1'b0;
    else         xchg_q <= take_o;
endmodule

// File: rtl/psr_flag_reg.sv
module psr_flag_reg
  import psr_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                acc_wr_i,
  input  logic [SR_W-1:0]     acc_wdata_i,
  input  logic                ien_clr_i,
  input  logic                ien_set_i,
  input  logic                entry_clr_i,
  input  logic                alu_we_i,
  input  logic                alu_ov_i,
  input  logic                alu_cy_i,
  input  logic [SNS_W-1:0]    sns_i,
  output psr_t                sr_o
);
  logic [USR_W-1:0] usr_q, usr_d;
  logic             ien_q, ien_d;
  logic             ov_q, ov_d, cy_q, cy_d;

  always_comb begin
    usr_d = usr_q;
    ien_d = ien_q;
    ov_d  = ov_q;
    cy_d  = cy_q;
    if (acc_wr_i) begin
      usr_d = acc_wdata_i[USR_W-1:0];
      ien_d = acc_wdata_i[BIT_IEN];
      ov_d  = acc_wdata_i[BIT_OV];
      cy_d  = acc_wdata_i[BIT_CY];
    end else begin
      if (ien_clr_i)      ien_d = 1'b0;
      else if (ien_set_i) ien_d = 1'b1;
      if (alu_we_i) begin
        ov_d = alu_ov_i;
        cy_d = alu_cy_i;
      end
    end
    if (entry_clr_i) ien_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      usr_q <= '0;
      ien_q <= 1'b0;
      ov_q  <= 1'b0;
      cy_q  <= 1'b0;
    end else begin
      usr_q <= usr_d;
      ien_q <= ien_d;
      ov_q  <= ov_d;
      cy_q  <= cy_d;
    end

  always_comb begin
    sr_o.usr   = usr_q;
    sr_o.ien   = ien_q;
    sr_o.sns_a = sns_i[0];
    sr_o.sns_b = sns_i[1];
    sr_o.ov    = ov_q;
    sr_o.cy    = cy_q;
  end
endmodule

// File: rtl/psr_irq_ctrl.sv
module psr_irq_ctrl
  import psr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_sense_i,
  input  logic             aux_sense_i,
  input  logic             acc_wr_i,
  input  logic [SR_W-1:0]  acc_wdata_i,
  input  logic             ien_clr_i,
  input  logic             ien_set_i,
  input  logic             alu_flag_we_i,
  input  logic             alu_ov_i,
  input  logic             alu_cy_i,
  input  logic             fetch_req_i,
  output logic             fetch_go_o,
  output logic             irq_xchg_o,
  output logic [SR_W-1:0]  sr_o,
  output logic [USR_W-1:0] usr_flag_o
);
  logic [SNS_W-1:0] sns_sync;
  logic             take;
  psr_t             sr;

  psr_sync #(.STAGES(SYNC_LEN), .W(SNS_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({aux_sense_i, irq_sense_i}),
    .q_o    (sns_sync)
  );

  psr_flag_reg u_reg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_wr_i    (acc_wr_i),
    .acc_wdata_i (acc_wdata_i),
    .ien_clr_i   (ien_clr_i),
    .ien_set_i   (ien_set_i),
    .entry_clr_i (take),
    .alu_we_i    (alu_flag_we_i),
    .alu_ov_i    (alu_ov_i),
    .alu_cy_i    (alu_cy_i),
    .sns_i       (sns_sync),
    .sr_o        (sr)
  );

  psr_irq_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fetch_req_i (fetch_req_i),
    .ien_i       (sr.ien),
    .req_i       (sr.sns_a),
    .take_o      (take),
    .xchg_o      (irq_xchg_o),
    .fetch_go_o  (fetch_go_o)
  );

  assign sr_o       = sr;
  assign usr_flag_o = sr.usr;
endmodule

// File: rtl/psr_irq_ctrl_chk.sv
module psr_irq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       acc_wr_i,
  input logic [7:0] acc_wdata_i,
  input logic       ien_clr_i,
  input logic       ien_set_i,
  input logic       alu_flag_we_i,
  input logic       alu_ov_i,
  input logic       alu_cy_i,
  input logic       fetch_req_i,
  input logic       fetch_go_o,
  input logic       irq_xchg_o,
  input logic [7:0] sr_o,
  input logic [2:0] usr_flag_o
);
  a_r8_xchg_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_xchg_o |=> !irq_xchg_o);
  a_r8_xchg_after_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_xchg_o |-> !sr_o[3] && !fetch_go_o);
  a_r7_take_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_i && sr_o[3] && sr_o[4] && !irq_xchg_o |=> irq_xchg_o);
  a_r7_go_or_xchg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fetch_go_o && irq_xchg_o));
  a_r2_acc_usr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_wr_i |=> usr_flag_o == $past(acc_wdata_i[2:0]));
  a_r6_alu_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_flag_we_i && !acc_wr_i |=> sr_o[7:6] == $past({alu_cy_i, alu_ov_i}));
  a_r3_clr_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ien_clr_i && !acc_wr_i |=> !sr_o[3]);
endmodule

bind psr_irq_ctrl psr_irq_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .acc_wr_i     (acc_wr_i),
  .acc_wdata_i  (acc_wdata_i),
  .ien_clr_i    (ien_clr_i),
  .ien_set_i    (ien_set_i),
  .alu_flag_we_i(alu_flag_we_i),
  .alu_ov_i     (alu_ov_i),
  .alu_cy_i     (alu_cy_i),
  .fetch_req_i  (fetch_req_i),
  .fetch_go_o   (fetch_go_o),
  .irq_xchg_o   (irq_xchg_o),
  .sr_o         (sr_o),
  .usr_flag_o   (usr_flag_o)
);

// File: tb/psr_irq_ctrl_tb_top.sv
module psr_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n, sa, sb, acc_wr, clr, set, alu_we, ov, cy, fetch;
  logic [7:0] wd;
  logic       go, xchg;
  logic [7:0] sr;
  logic [2:0] usr;

  psr_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .irq_sense_i(sa), .aux_sense_i(sb),
    .acc_wr_i(acc_wr), .acc_wdata_i(wd), .ien_clr_i(clr), .ien_set_i(set),
    .alu_flag_we_i(alu_we), .alu_ov_i(ov), .alu_cy_i(cy), .fetch_req_i(fetch),
    .fetch_go_o(go), .irq_xchg_o(xchg), .sr_o(sr), .usr_flag_o(usr)
  );

  int total = 0, bad = 0;
  bit done = 0;

  logic [2:0] m_usr;
  logic       m_ien, m_ov, m_cy, m_xq;
  logic [1:0] m_s1, m_s2;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic m_take();
    return fetch && m_ien && m_s2[0] && !m_xq;
  endfunction

  task automatic idle();
    acc_wr = 0; wd = '0; clr = 0; set = 0; alu_we = 0; ov = 0; cy = 0; fetch = 0;
  endtask

  // inputs already driven after a falling edge; compare, advance, update model
  task automatic step();
    logic       tk;
    logic [2:0] n_usr;
    logic       n_ien, n_ov, n_cy;
    #1;
    tk = m_take();
    chk("R7 fetch_go", go, fetch && !tk && !m_xq);
    chk("R8 xchg", xchg, m_xq);
    chk("R3 ien", sr[3], m_ien);
    chk("R5 sense", sr[5:4], m_s2);
    chk("R6 ov_cy", sr[7:6], {m_cy, m_ov});
    chk("R2 usr", {sr[2:0], usr}, {m_usr, m_usr});
    n_usr = acc_wr ? wd[2:0] : m_usr;
    n_ien = acc_wr ? wd[3] : clr ? 1'b0 : set ? 1'b1 : m_ien;
    if (tk) n_ien = 1'b0;  // R9
    n_ov = acc_wr ? wd[6] : alu_we ? ov : m_ov;
    n_cy = acc_wr ? wd[7] : alu_we ? cy : m_cy;
    @(posedge clk);
    m_s2 = m_s1; m_s1 = {sb, sa};
    m_usr = n_usr; m_ien = n_ien; m_ov = n_ov; m_cy = n_cy; m_xq = tk;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; sa = 1; sb = 1; idle();
    m_usr = '0; m_ien = 0; m_ov = 0; m_cy = 0; m_xq = 0; m_s1 = '0; m_s2 = '0;
    repeat (3) @(negedge clk);
    // R1 reset state, with sense lines high during reset
    chk("R1 sr", sr, 8'h00);
    chk("R1 xchg", xchg, 1'b0);
    chk("R1 usr", usr, 3'b000);
    sa = 0; sb = 0;
    rst_n = 1;
    step();
    chk("R1 after release", sr, 8'h00);

    // R3 set then clear-vs-set conflict
    set = 1; step();
    chk("R3 set", sr[3], 1'b1);
    clr = 1; step();
    chk("R3 clr wins", sr[3], 1'b0);
    idle();

    // R4 acc write of all ones: bits 4,5 ignored, priority over clr and alu
    acc_wr = 1; wd = 8'hFF; clr = 1; alu_we = 1; step();
    idle();
    chk("R4 write", sr, 8'hCF);
    acc_wr = 1; wd = 8'h30; step(); idle();
    chk("R4 sense bits ignored", sr, 8'h00);

    // R5 two-edge latency
    sb = 1; step();
    chk("R5 one edge", sr[5], 1'b0);
    step();
    chk("R5 two edges", sr[5], 1'b1);
    sb = 0;

    // R6 alu update
    alu_we = 1; ov = 1; cy = 0; step(); idle();
    chk("R6 alu", sr[7:6], 2'b01);

    // R7/R8/R9 take with conflicting set and acc write of bit 3
    set = 1; sa = 1; step(); step(); idle();
    fetch = 1; set = 1; acc_wr = 1; wd = 8'h0F;
    #1 chk("R8 no go on take", go, 1'b0);
    step();
    chk("R9 entry clear wins", sr[3], 1'b0);
    chk("R8 xchg pulse", xchg, 1'b1);
    idle(); fetch = 1; step();
    chk("R8 pulse ends", xchg, 1'b0);
    chk("R7 go resumes", go, 1'b1);
    idle(); sa = 0; step(); step();

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      fetch  = r[0] | r[1];
      acc_wr = (r[4:2] == 3'd0);
      wd     = 8'($urandom);
      clr    = (r[7:5] == 3'd0);
      set    = r[8] & r[9];
      alu_we = r[10];
      ov     = r[11];
      cy     = r[12];
      if (r[16:13] == 4'd0) sa = ~sa;
      if (r[19:17] == 3'd0) sb = ~sb;
      step();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule